// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches one asynchronous input pin. When a chosen event happens on that pin, it copies the current value of a free-running 16-bit timer into a capture register. There are four events: every falling edge, every rising edge, every 4th rising edge, or every 16th rising edge. The timer is outside the block and arrives as a bus. The pin first passes through a two-flop synchronizer. An edge detector and an event prescaler follow it.

Each capture sets a sticky interrupt flag. Software clears the flag by writing zero to it. A capture that arrives before software has read the register overwrites the older value, and nothing records the loss.

The prescaler keeps its count across a direct switch from one capture mode to another. It is cleared only by reset, by the off code, or by a non-capture code. The edge detector works on the input level after the polarity of the current mode has been applied. Because of this, a change of mode polarity can raise a spurious capture. This matches the behaviour that software is expected to guard against.

Top module: `capture_unit`

## Requirements
- R1: A qualifying event copies the whole timer bus into {cap_hi, cap_lo} in one clock. If the pin settles before clock edge t, the capture takes place at edge t+2 and holds the tmr_value present at that edge. At every other edge the register holds its value.
- R2: mode_q takes mode_wr_data one clock after mode_wr_en. Mode code 4'b0100 captures on falling edges only, and 4'b0101 captures on rising edges only.
- R3: Mode 4'b0110 captures on every 4th counted edge. This is the edge that finds the low two bits of the 4-bit prescaler at 2'b11.
- R4: Mode 4'b0111 captures on every 16th counted edge. This is the edge that finds the prescaler at 4'b1111.
- R5: Each capture sets irq_flag. It stays set until a write with flag_wr_en=1 and flag_wr_data=0. Writing 1 has no effect. A clear and a capture in the same clock leave the flag set.
- R6: A second capture overwrites the first even if the first was never read. There is no overflow indication.
- R7: The prescaler is cleared by reset, by mode 4'b0000, and by any code outside 4'b0100 to 4'b0111.
- R8: A direct switch between capture codes keeps the prescaler count. After 5 edges in mode 4'b0111, a switch to 4'b0110 captures on the 3rd further rising edge.
- R9: Edges are detected on the synchronized pin XOR (mode == 4'b0100). A mode change that turns this level from 0 to 1 gives one spurious capture, one clock after mode_q updates. Examples: rising to falling with the pin low, off to falling with the pin low, falling to rising with the pin high.
- R10: Under a non-capture code, pin edges cause no capture and leave irq_flag unchanged.
- R11: After reset, mode_q, cap_hi, cap_lo and irq_flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_value | input | 16 | Free-running timer value |
| mode_wr_en | input | 1 | Write strobe for the mode field |
| mode_wr_data | input | 4 | New mode code |
| flag_wr_en | input | 1 | Write strobe for the interrupt flag |
| flag_wr_data | input | 1 | Flag write data (0 clears, 1 ignored) |
| mode_q | output | 4 | Current mode field |
| cap_hi | output | 8 | Capture register, high byte |
| cap_lo | output | 8 | Capture register, low byte |
| irq_flag | output | 1 | Sticky capture interrupt flag |

## Verification
Pin pulses are applied in each capture mode. Rising-only and falling-only phases separate the two edge polarities, and trains of 4 and 16 pulses separate the divide ratios. Two mode patterns probe the prescaler. A pass through off or a non-capture code, then back, shows that the count was cleared. A direct switch from divide-by-16 to divide-by-4 shows that the count was kept. Mode writes made while the pin sits at a fixed level show whether a polarity change produces the expected spurious capture. A flag clear timed onto the capture clock shows the set-wins rule, and timer values that differ every cycle show the two-clock latency.

// File: rtl/cap_pkg.sv
// Package: shared widths, mode codes and mode helpers for the capture unit.
// Assumes a 4-bit mode field. Codes 4'b0100..4'b0111 are the capture modes.
package cap_pkg;

    localparam int MODE_W = 4;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_OFF    = 4'b0000;
    localparam mode_t MODE_FALL   = 4'b0100;
    localparam mode_t MODE_RISE   = 4'b0101;
    localparam mode_t MODE_RISE4  = 4'b0110;
    localparam mode_t MODE_RISE16 = 4'b0111;

    // True for any of the four capture codes.
    function automatic logic is_capture(input mode_t m);
        return (m[3:2] == 2'b01);
    endfunction

    // True when the edge detector must look at the inverted pin level.
    function automatic logic is_inverted(input mode_t m);
        return (m == MODE_FALL);
    endfunction

endpackage

// File: rtl/cap_sync.sv
// Module: cap_sync
// Brings the asynchronous pin into the clk domain through STAGES flops.
// Assumes STAGES >= 1. The reset value of every stage is 0.
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= 1'b0;
                else        stg[i] <= pin_async;
            end
        end else begin : g_next
            // Later stages take the value of the stage before them.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= 1'b0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign pin_sync = stg[STAGES-1];

endmodule

// File: rtl/cap_edge.sv
// Module: cap_edge
// Flags a qualifying edge on the synchronized pin. The pin is first XORed with
// the polarity of the current mode, and a 0->1 change of that level is an edge.
// The previous level is registered in every mode, so a polarity change can
// itself look like an edge. That spurious edge is intended.
module cap_edge
    import cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_sync,
    input  mode_t mode,
    output logic  edge_o
);

    logic lvl_now;
    logic lvl_prev;

    // Polarity-adjusted level of the pin.
    always_comb lvl_now = pin_sync ^ is_inverted(mode);

    // Remember the level from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl_now;
    end

    // A qualifying edge exists only in a capture mode.
    always_comb edge_o = is_capture(mode) & lvl_now & ~lvl_prev;

endmodule

// File: rtl/cap_prescale.sv
// Module: cap_prescale
// Counts qualifying edges and decides which of them fire a capture.
// The count is cleared by reset and by any non-capture mode. A switch between
// capture modes leaves the count as it was.
module cap_prescale
    import cap_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic             edge_i,
    output logic             fire_o,
    output logic [PRE_W-1:0] count_o
);

    localparam int LOW_W = 2;

    logic [PRE_W-1:0] cnt;

    // Count edges in capture modes. Clear the count otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (!is_capture(mode)) cnt <= '0;
        else if (edge_i)            cnt <= cnt + 1'b1;
    end

    // Choose the firing edge from the mode and the count before this edge.
    always_comb begin
        fire_o = 1'b0;
        if (edge_i) begin
            unique case (mode)
                MODE_FALL, MODE_RISE: fire_o = 1'b1;
                MODE_RISE4:           fire_o = &cnt[LOW_W-1:0];
                MODE_RISE16:          fire_o = &cnt;
                default:              fire_o = 1'b0;
            endcase
        end
    end

    assign count_o = cnt;

endmodule

// File: rtl/cap_regs.sv
// Module: cap_regs
// Holds the mode field, the capture register and the sticky flag.
// If a capture and a flag clear land in the same clock, the flag stays set.
module cap_regs
    import cap_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [TMR_W-1:0] tmr_value,
    input  logic             mode_wr_en,
    input  mode_t            mode_wr_data,
    input  logic             flag_wr_en,
    input  logic             flag_wr_data,
    output mode_t            mode_q,
    output logic [TMR_W-1:0] cap_value,
    output logic             flag_q
);

    logic flag_clr;

    // Mode field register.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_q <= MODE_OFF;
        else if (mode_wr_en) mode_q <= mode_wr_data;
    end

    // Capture register: loads the timer on a fire and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_value <= '0;
        else if (fire_i) cap_value <= tmr_value;
    end

    // A clear is a flag write of zero.
    always_comb flag_clr = flag_wr_en & ~flag_wr_data;

    // Sticky flag. Setting has priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (fire_i)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

endmodule

// File: rtl/capture_unit.sv
// Module: capture_unit (top)
// Input capture unit: synchronizer, then edge detector, then prescaler, then
// registers. The timer is external and arrives as tmr_value. The capture
// register is split into high and low bytes for reading.
module capture_unit
    import cap_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_pin,
    input  logic [TMR_W-1:0]   tmr_value,
    input  logic               mode_wr_en,
    input  logic [MODE_W-1:0]  mode_wr_data,
    input  logic               flag_wr_en,
    input  logic               flag_wr_data,
    output logic [MODE_W-1:0]  mode_q,
    output logic [TMR_W/2-1:0] cap_hi,
    output logic [TMR_W/2-1:0] cap_lo,
    output logic               irq_flag
);

    localparam int HALF_W = TMR_W / 2;

    logic             pin_sync;
    logic             edge_evt;
    logic             cap_strobe;
    logic [PRE_W-1:0] pre_cnt;
    logic [TMR_W-1:0] cap_value;
    mode_t            mode_r;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cap_pin),
        .pin_sync  (pin_sync)
    );

    cap_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .mode     (mode_r),
        .edge_o   (edge_evt)
    );

    cap_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_r),
        .edge_i  (edge_evt),
        .fire_o  (cap_strobe),
        .count_o (pre_cnt)
    );

    cap_regs #(.TMR_W(TMR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (cap_strobe),
        .tmr_value    (tmr_value),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .flag_wr_en   (flag_wr_en),
        .flag_wr_data (flag_wr_data),
        .mode_q       (mode_r),
        .cap_value    (cap_value),
        .flag_q       (irq_flag)
    );

    assign mode_q = mode_r;
    assign cap_hi = cap_value[TMR_W-1:HALF_W];
    assign cap_lo = cap_value[HALF_W-1:0];

endmodule

// File: rtl/cap_checker.sv
// Module: cap_checker
// Properties over the capture unit's ports and its internal strobes.
// It is attached to every capture_unit instance by the bind below.
module cap_checker
    import cap_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int PRE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TMR_W-1:0]   tmr_value,
    input logic               mode_wr_en,
    input logic [MODE_W-1:0]  mode_wr_data,
    input logic               flag_wr_en,
    input logic               flag_wr_data,
    input logic [MODE_W-1:0]  mode_q,
    input logic [TMR_W/2-1:0] cap_hi,
    input logic [TMR_W/2-1:0] cap_lo,
    input logic               irq_flag,
    input logic               cap_strobe,
    input logic [PRE_W-1:0]   pre_cnt
);

    a_r1_load_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> ({cap_hi, cap_lo} == $past(tmr_value)));

    a_r1_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_strobe |=> $stable({cap_hi, cap_lo}));

    a_r2_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |=> (mode_q == $past(mode_wr_data)));

    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> irq_flag);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(flag_wr_en && !flag_wr_data)) |=> irq_flag);

    a_r7_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode_q) |=> (pre_cnt == '0));

    a_r10_no_fire_off: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode_q) |-> !cap_strobe);

endmodule

bind capture_unit cap_checker #(.TMR_W(TMR_W), .PRE_W(PRE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_value    (tmr_value),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .flag_wr_en   (flag_wr_en),
    .flag_wr_data (flag_wr_data),
    .mode_q       (mode_q),
    .cap_hi       (cap_hi),
    .cap_lo       (cap_lo),
    .irq_flag     (irq_flag),
    .cap_strobe   (cap_strobe),
    .pre_cnt      (pre_cnt)
);

// File: tb/tb_capture_unit.sv
// Bench for capture_unit. A behavioural reference model is compared with the
// outputs on every clock, and directed checks cover each requirement.
module tb_capture_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] tmr_value = 16'h0000;
    logic        mode_wr_en = 1'b0;
    logic [3:0]  mode_wr_data = 4'h0;
    logic        flag_wr_en = 1'b0;
    logic        flag_wr_data = 1'b0;
    logic [3:0]  mode_q;
    logic [7:0]  cap_hi;
    logic [7:0]  cap_lo;
    logic        irq_flag;

    int errors = 0;
    int checks = 0;
    bit compare_on = 0;
    bit done = 0;

    // Reference model state.
    int m_s1, m_s2, m_qd, m_cnt, m_mode, m_cap, m_flag;
    int caps_seen = 0;
    int last_cap = 0;

    capture_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_pin      (cap_pin),
        .tmr_value    (tmr_value),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .flag_wr_en   (flag_wr_en),
        .flag_wr_data (flag_wr_data),
        .mode_q       (mode_q),
        .cap_hi       (cap_hi),
        .cap_lo       (cap_lo),
        .irq_flag     (irq_flag)
    );

    always #5 clk = ~clk;

    // Timer advances by a distinct step every cycle.
    always @(negedge clk) tmr_value <= tmr_value + 16'd37;

    // Behavioural reference, updated at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_qd = 0; m_cnt = 0; m_mode = 0; m_cap = 0; m_flag = 0;
        end else begin
            int q; bit capm; bit ev; bit fire;
            q = m_s2 ^ ((m_mode == 4) ? 1 : 0);
            capm = (m_mode >= 4 && m_mode <= 7);
            ev = capm && q == 1 && m_qd == 0;
            fire = 0;
            if (ev) begin
                if (m_mode == 4 || m_mode == 5) fire = 1;
                else if (m_mode == 6) fire = ((m_cnt % 4) == 3);
                else fire = (m_cnt == 15);
            end
            if (!capm) m_cnt = 0;
            else if (ev) m_cnt = (m_cnt + 1) % 16;
            if (fire) m_cap = int'(tmr_value);
            if (fire) m_flag = 1;
            else if (flag_wr_en && !flag_wr_data) m_flag = 0;
            m_qd = q;
            m_s2 = m_s1;
            m_s1 = int'(cap_pin);
            if (mode_wr_en) m_mode = int'(mode_wr_data);
        end
    end

    // Per-cycle comparison, plus a count of captures seen at the ports.
    always @(negedge clk) begin
        if (compare_on) begin
            checks++;
            if (int'({cap_hi, cap_lo}) != m_cap) begin
                errors++;
                $display("FAIL R1 capture value: got %h expected %h", {cap_hi, cap_lo}, m_cap[15:0]);
            end
            checks++;
            if (int'(irq_flag) != m_flag) begin
                errors++;
                $display("FAIL R5 flag: got %0d expected %0d", irq_flag, m_flag);
            end
            checks++;
            if (int'(mode_q) != m_mode) begin
                errors++;
                $display("FAIL R2 mode: got %0d expected %0d", mode_q, m_mode);
            end
            if (int'({cap_hi, cap_lo}) != last_cap) caps_seen++;
            last_cap = int'({cap_hi, cap_lo});
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_data = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
        cycles(4);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_wr_en = 1'b1; flag_wr_data = 1'b0;
        @(negedge clk);
        flag_wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cap_pin = 1'b1;
            cycles(4);
            cap_pin = 1'b0;
            cycles(4);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        int expv;
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        compare_on = 1;
        last_cap = int'({cap_hi, cap_lo});
        // R11 reset state
        check("R11 mode after reset", int'(mode_q), 0);
        check("R11 capture after reset", int'({cap_hi, cap_lo}), 0);
        check("R11 flag after reset", int'(irq_flag), 0);

        // R10 non-capture codes ignore the pin
        set_mode(4'b1000);
        base = caps_seen;
        pulses(3);
        check("R10 no capture in code 1000", caps_seen - base, 0);
        check("R10 flag untouched", int'(irq_flag), 0);

        // R1 latency: the pin rises before edge t, and the capture is at edge t+2
        set_mode(4'b0101);
        @(negedge clk); cap_pin = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk);
        expv = int'(tmr_value);
        @(negedge clk);
        check("R1 capture takes timer at edge t+2", int'({cap_hi, cap_lo}), expv);
        check("R5 flag set by capture", int'(irq_flag), 1);
        cycles(3); cap_pin = 1'b0; cycles(4);

        // R5 writing 1 has no effect, writing 0 clears
        @(negedge clk); flag_wr_en = 1'b1; flag_wr_data = 1'b1;
        @(negedge clk); flag_wr_en = 1'b0;
        check("R5 write of 1 keeps flag", int'(irq_flag), 1);
        clear_flag();
        check("R5 write of 0 clears flag", int'(irq_flag), 0);

        // R5 a clear in the capture clock loses to the set
        @(negedge clk); cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); flag_wr_en = 1'b1; flag_wr_data = 1'b0;
        @(negedge clk); flag_wr_en = 1'b0;
        check("R5 set wins over same-cycle clear", int'(irq_flag), 1);
        cycles(3); cap_pin = 1'b0; cycles(4);

        // R2 rising mode: one capture per pulse
        base = caps_seen;
        pulses(3);
        check("R2 rising mode captures per pulse", caps_seen - base, 3);

        // R6 overwrite without read
        check("R6 register holds latest capture", int'({cap_hi, cap_lo}), m_cap);

        // R9 rising to falling with the pin low gives a spurious capture
        clear_flag();
        base = caps_seen;
        set_mode(4'b0100);
        check("R9 spurious capture on polarity change", caps_seen - base, 1);
        check("R9 spurious flag set", int'(irq_flag), 1);

        // R2 falling mode: one capture per pulse
        base = caps_seen;
        pulses(2);
        check("R2 falling mode captures per pulse", caps_seen - base, 2);

        // R9 falling to rising with the pin high
        @(negedge clk); cap_pin = 1'b1; cycles(4);
        base = caps_seen;
        set_mode(4'b0101);
        check("R9 spurious capture falling to rising", caps_seen - base, 1);
        @(negedge clk); cap_pin = 1'b0; cycles(4);

        // R3 divide by 4
        set_mode(4'b0000);
        set_mode(4'b0110);
        base = caps_seen;
        pulses(3);
        check("R3 no capture after 3 edges", caps_seen - base, 0);
        pulses(1);
        check("R3 capture on 4th edge", caps_seen - base, 1);
        pulses(4);
        check("R3 capture on 8th edge", caps_seen - base, 2);

        // R7 leaving capture mode clears the count
        pulses(2);
        set_mode(4'b0000);
        set_mode(4'b0110);
        base = caps_seen;
        pulses(3);
        check("R7 count cleared by off", caps_seen - base, 0);
        pulses(1);
        check("R7 capture after 4 fresh edges", caps_seen - base, 1);
        pulses(2);
        set_mode(4'b1011);
        set_mode(4'b0110);
        base = caps_seen;
        pulses(3);
        check("R7 count cleared by code 1011", caps_seen - base, 0);
        pulses(1);

        // R4 divide by 16
        set_mode(4'b0000);
        set_mode(4'b0111);
        base = caps_seen;
        pulses(15);
        check("R4 no capture after 15 edges", caps_seen - base, 0);
        pulses(1);
        check("R4 capture on 16th edge", caps_seen - base, 1);

        // R8 direct switch keeps the count
        set_mode(4'b0000);
        set_mode(4'b0111);
        pulses(5);
        set_mode(4'b0110);
        base = caps_seen;
        pulses(2);
        check("R8 no capture after 2 edges", caps_seen - base, 0);
        pulses(1);
        check("R8 early capture on 3rd edge", caps_seen - base, 1);

        // R9 off to falling with the pin low
        set_mode(4'b0000);
        base = caps_seen;
        set_mode(4'b0100);
        check("R9 spurious capture off to falling", caps_seen - base, 1);

        cycles(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule